// File: doc/BRIEF.md
# Standby Power Mode Controller

This block is the always-on sequencer that moves a small processor system into its deepest standby state and back out again. When the core issues a sleep request (wait-for-interrupt or wait-for-event), the controller checks the deep-sleep select, the power-down select and its own retained wake flag. If all three allow it, the controller isolates the general I/O and then removes power from the switchable domain.

Standby is left only through a full reset. A rising edge on the wakeup pin (when that pin is enabled) or on the alarm event ends standby. So does a watchdog reset or an external reset. In every case the controller drives a system reset request for a fixed number of cycles and then returns to run.

Two flags survive the reset in a small always-on register. One records that standby was entered. The other records that a pin or alarm event caused the exit. Software clears each flag with its own clear strobe, and an external reset clears both. After a restart, software can therefore tell a standby wakeup from a cold reset. All inputs except the wakeup pin and the alarm are treated as synchronous to the clock.

Top module: `stby_seq`

## Requirements
- R1: With the core sleep request, deep-sleep select and power-down select all high and the wake flag low at a clock edge, the controller enters a one-cycle isolation step. In that step every bit of the general I/O high-impedance vector is 1 and the domain power-down output is 0. At the following edge it enters standby.
- R2: If any one of sleep request, deep-sleep select or power-down select is low, or the wake flag is set, a sleep request does not start the entry sequence and the I/O stays driven.
- R3: In standby, a rising edge on the wakeup pin (only when the wakeup-pin enable is high) or on the alarm input ends standby. The system reset request rises SYNC_STAGES+1 edges after the input changes. A level that is already high when standby is entered causes no exit, and a rising pin edge while the pin enable is low is ignored.
- R4: Every exit drives the system reset request high for exactly RST_CYCLES consecutive cycles. The controller then returns to run with the reset request low and the I/O driven.
- R5: The standby flag is set at the edge where standby is entered. It is cleared by the standby-flag clear strobe.
- R6: The wake flag is set at the edge where a pin or alarm edge ends standby. A watchdog exit does not set it. It is cleared by the wake-flag clear strobe.
- R7: An external reset pulse starts the reset sequence from any state and clears both flags at the same edge. A watchdog reset pulse starts the same sequence and leaves both flags unchanged.
- R8: The general I/O high-impedance vector is all ones in every state except run. In those states the tamper pad is high-impedance unless tamper output is configured, and the wakeup pad is high-impedance unless the wakeup pin is enabled.
- R9: The domain power-down output is high only in the standby state and is 0 after the always-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| aon_rst_ni | input | 1 | Always-on power-on reset, active low, asynchronous |
| core_sleep_i | input | 1 | Core wait-for-interrupt/event sleep request |
| deep_sel_i | input | 1 | Deep-sleep select bit |
| pwrdn_sel_i | input | 1 | Power-down-in-deep-sleep select bit |
| wkup_pin_i | input | 1 | Wakeup pin, asynchronous |
| wkup_en_i | input | 1 | Wakeup pin enable |
| alarm_i | input | 1 | Alarm event, asynchronous |
| tamper_cfg_i | input | 1 | Tamper/calibration output configured |
| ext_rst_i | input | 1 | External reset request pulse |
| wdg_rst_i | input | 1 | Watchdog reset request pulse |
| clr_stby_i | input | 1 | Software clear strobe for the standby flag |
| clr_wake_i | input | 1 | Software clear strobe for the wake flag |
| dom_pd_o | output | 1 | Switchable domain power-down enable |
| sys_rst_req_o | output | 1 | System reset request |
| gpio_hiz_o | output | N_IO | High-impedance control for general I/O |
| tamper_hiz_o | output | 1 | High-impedance control for the tamper pad |
| wkup_pad_hiz_o | output | 1 | High-impedance control for the wakeup pad |
| stby_flag_o | output | 1 | Retained standby flag |
| wake_flag_o | output | 1 | Retained wake flag |

## Verification
A wrong sequencer state shows up directly at the ports. The power-down or I/O isolation outputs would rise or fall one cycle off the expected edge, or the reset request pulse would have the wrong length, and a scoreboard measures that length on every exit. A broken edge detector shows either as a reset request that never comes within SYNC_STAGES+1 edges or as a spurious exit while a level is held high. Flag faults are visible on the retained flag outputs at the edge after entry, exit or a clear strobe, and again as a blocked or allowed next entry.

// File: rtl/stby_pkg.sv
package stby_pkg;
   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_ISO   = 2'd1,
      ST_STBY  = 2'd2,
      ST_WRST  = 2'd3
   } stby_state_e;

   localparam int unsigned WAKE_SRC  = 2;
   localparam int unsigned SRC_PIN   = 0;
   localparam int unsigned SRC_ALARM = 1;
endpackage

// File: rtl/stby_edge_det.sv
module stby_edge_det #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic rise_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;
   logic              level;

   initial begin : elab_chk
      assert (STAGES >= 1) else $error("stby_edge_det: STAGES must be at least 1");
   end

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '0;
            else         chain_q <= async_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '0;
            else         chain_q <= {chain_q[STAGES-2:0], async_i};
         end
      end
   endgenerate

   assign level = chain_q[STAGES-1];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= level;
   end

   assign rise_o = level & ~prev_q;

   p_single_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |=> !rise_o);
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
   import stby_pkg::*;
#(
   parameter int unsigned RST_CYCLES = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sleep_i,
   input  logic deep_i,
   input  logic pwrdn_i,
   input  logic wake_flag_i,
   input  logic wake_evt_i,
   input  logic ext_rst_i,
   input  logic wdg_rst_i,
   output logic pd_en_o,
   output logic sys_rst_o,
   output logic iso_o,
   output logic stby_set_o,
   output logic wake_set_o
);
   localparam int unsigned CW = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;
   localparam logic [CW-1:0] CNT_LAST = CW'(RST_CYCLES - 1);

   initial begin : elab_chk
      assert (RST_CYCLES >= 2) else $error("stby_fsm: RST_CYCLES must be at least 2");
   end

   stby_state_e   state_q, state_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          go;
   logic          any_rst;

   assign go      = sleep_i & deep_i & pwrdn_i & ~wake_flag_i;
   assign any_rst = ext_rst_i | wdg_rst_i;

   always_comb begin
      state_d    = state_q;
      cnt_d      = cnt_q;
      stby_set_o = 1'b0;
      wake_set_o = 1'b0;
      if (any_rst) begin
         state_d = ST_WRST;
         cnt_d   = CNT_LAST;
      end else begin
         case (state_q)
            ST_RUN: begin
               if (go) state_d = ST_ISO;
            end
            ST_ISO: begin
               state_d    = ST_STBY;
               stby_set_o = 1'b1;
            end
            ST_STBY: begin
               if (wake_evt_i) begin
                  state_d    = ST_WRST;
                  cnt_d      = CNT_LAST;
                  wake_set_o = 1'b1;
               end
            end
            ST_WRST: begin
               if (cnt_q == '0) state_d = ST_RUN;
               else             cnt_d   = cnt_q - CW'(1);
            end
            default: state_d = ST_RUN;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_RUN;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign pd_en_o   = (state_q == ST_STBY);
   assign sys_rst_o = (state_q == ST_WRST);
   assign iso_o     = (state_q != ST_RUN);

   p_entry_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_RUN && go && !any_rst) |=> (state_q == ST_ISO));

   p_flag_blocks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_RUN && wake_flag_i) |=> (state_q != ST_ISO));

   p_hold_reset_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_WRST && cnt_q != '0 && !any_rst) |=> (state_q == ST_WRST));

   p_standby_via_iso_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pd_en_o) |-> $past(state_q == ST_ISO));
endmodule

// File: rtl/stby_flags.sv
module stby_flags (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic stby_set_i,
   input  logic wake_set_i,
   input  logic clr_stby_i,
   input  logic clr_wake_i,
   input  logic ext_rst_i,
   output logic stby_q_o,
   output logic wake_q_o
);
   logic stby_q, wake_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stby_q <= 1'b0;
         wake_q <= 1'b0;
      end else begin
         if (ext_rst_i)       stby_q <= 1'b0;
         else if (stby_set_i) stby_q <= 1'b1;
         else if (clr_stby_i) stby_q <= 1'b0;

         if (ext_rst_i)       wake_q <= 1'b0;
         else if (wake_set_i) wake_q <= 1'b1;
         else if (clr_wake_i) wake_q <= 1'b0;
      end
   end

   assign stby_q_o = stby_q;
   assign wake_q_o = wake_q;

   p_ext_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext_rst_i |=> (!stby_q && !wake_q));

   p_wake_only_on_event_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wake_set_i |=> !$rose(wake_q));

   p_stby_only_on_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !stby_set_i |=> !$rose(stby_q));
endmodule

// File: rtl/stby_seq.sv
module stby_seq
   import stby_pkg::*;
#(
   parameter int unsigned N_IO        = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RST_CYCLES  = 16
) (
   input  logic            clk_i,
   input  logic            aon_rst_ni,
   input  logic            core_sleep_i,
   input  logic            deep_sel_i,
   input  logic            pwrdn_sel_i,
   input  logic            wkup_pin_i,
   input  logic            wkup_en_i,
   input  logic            alarm_i,
   input  logic            tamper_cfg_i,
   input  logic            ext_rst_i,
   input  logic            wdg_rst_i,
   input  logic            clr_stby_i,
   input  logic            clr_wake_i,
   output logic            dom_pd_o,
   output logic            sys_rst_req_o,
   output logic [N_IO-1:0] gpio_hiz_o,
   output logic            tamper_hiz_o,
   output logic            wkup_pad_hiz_o,
   output logic            stby_flag_o,
   output logic            wake_flag_o
);
   initial begin : elab_chk
      assert (N_IO >= 1) else $error("stby_seq: N_IO must be at least 1");
   end

   logic [WAKE_SRC-1:0] src_raw, src_rise, src_en;
   logic                wake_evt, iso, stby_set, wake_set, wake_q, stby_q;

   assign src_raw[SRC_PIN]   = wkup_pin_i;
   assign src_raw[SRC_ALARM] = alarm_i;
   assign src_en[SRC_PIN]    = wkup_en_i;
   assign src_en[SRC_ALARM]  = 1'b1;

   for (genvar gi = 0; gi < WAKE_SRC; gi++) begin : g_src
      stby_edge_det #(.STAGES(SYNC_STAGES)) u_det (
         .clk_i  (clk_i),
         .rst_ni (aon_rst_ni),
         .async_i(src_raw[gi]),
         .rise_o (src_rise[gi])
      );
   end

   assign wake_evt = |(src_rise & src_en);

   stby_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (aon_rst_ni),
      .sleep_i    (core_sleep_i),
      .deep_i     (deep_sel_i),
      .pwrdn_i    (pwrdn_sel_i),
      .wake_flag_i(wake_q),
      .wake_evt_i (wake_evt),
      .ext_rst_i  (ext_rst_i),
      .wdg_rst_i  (wdg_rst_i),
      .pd_en_o    (dom_pd_o),
      .sys_rst_o  (sys_rst_req_o),
      .iso_o      (iso),
      .stby_set_o (stby_set),
      .wake_set_o (wake_set)
   );

   stby_flags u_flags (
      .clk_i     (clk_i),
      .rst_ni    (aon_rst_ni),
      .stby_set_i(stby_set),
      .wake_set_i(wake_set),
      .clr_stby_i(clr_stby_i),
      .clr_wake_i(clr_wake_i),
      .ext_rst_i (ext_rst_i),
      .stby_q_o  (stby_q),
      .wake_q_o  (wake_q)
   );

   assign gpio_hiz_o     = {N_IO{iso}};
   assign tamper_hiz_o   = iso & ~tamper_cfg_i;
   assign wkup_pad_hiz_o = iso & ~wkup_en_i;
   assign stby_flag_o    = stby_q;
   assign wake_flag_o    = wake_q;

   p_isolated_when_off_r8: assert property (@(posedge clk_i) disable iff (!aon_rst_ni)
      dom_pd_o |-> (&gpio_hiz_o));

   p_no_pd_in_reset_r9: assert property (@(posedge clk_i) disable iff (!aon_rst_ni)
      sys_rst_req_o |-> !dom_pd_o);
endmodule

// File: tb/stby_seq_test.sv
module stby_seq_test;
   localparam int unsigned N_IO  = 16;
   localparam int unsigned SYNC  = 2;
   localparam int unsigned RSTC  = 16;

   logic clk = 1'b0;
   logic aon_rst_n = 1'b0;
   logic sleep = 0, deep = 0, pwrdn = 0, pin = 0, pin_en = 0, alarm = 0;
   logic tamper_cfg = 0, ext_rst = 0, wdg_rst = 0, clr_stby = 0, clr_wake = 0;
   logic            dom_pd, sys_rst;
   logic [N_IO-1:0] gpio_hiz;
   logic            tamper_hiz, wkup_hiz, stby_flag, wake_flag;

   always #2.5 clk = ~clk;

   stby_seq #(.N_IO(N_IO), .SYNC_STAGES(SYNC), .RST_CYCLES(RSTC)) uut (
      .clk_i(clk), .aon_rst_ni(aon_rst_n), .core_sleep_i(sleep), .deep_sel_i(deep),
      .pwrdn_sel_i(pwrdn), .wkup_pin_i(pin), .wkup_en_i(pin_en), .alarm_i(alarm),
      .tamper_cfg_i(tamper_cfg), .ext_rst_i(ext_rst), .wdg_rst_i(wdg_rst),
      .clr_stby_i(clr_stby), .clr_wake_i(clr_wake), .dom_pd_o(dom_pd),
      .sys_rst_req_o(sys_rst), .gpio_hiz_o(gpio_hiz), .tamper_hiz_o(tamper_hiz),
      .wkup_pad_hiz_o(wkup_hiz), .stby_flag_o(stby_flag), .wake_flag_o(wake_flag));

   typedef struct packed {
      int unsigned len;
      logic        stby;
      logic        wake;
   } exp_t;

   exp_t        sb_q[$];
   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;
   int unsigned hi_cnt = 0;
   logic        done = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic push_exit(input logic s, input logic w);
      exp_t e;
      e.len = RSTC; e.stby = s; e.wake = w;
      sb_q.push_back(e);
   endtask

   task automatic wait_exit_done();
      for (int i = 0; i < 64 && sys_rst; i++) tick();
      tick();
      chk("R4 back to run, I/O driven", 32'(gpio_hiz), 32'(0));
   endtask

   task automatic enter_standby();
      sleep = 1; deep = 1; pwrdn = 1;
      tick();
      chk("R1 isolation step hiz", 32'(gpio_hiz), 32'({N_IO{1'b1}}));
      chk("R1 isolation step no pd", 32'(dom_pd), 32'(0));
      sleep = 0;
      tick();
      chk("R9 pd in standby", 32'(dom_pd), 32'(1));
      chk("R5 standby flag set", 32'(stby_flag), 32'(1));
   endtask

   // monitor: measures every reset pulse and compares against the scoreboard (R4)
   always @(negedge clk) begin
      if (aon_rst_n) begin
         if (sys_rst) hi_cnt <= hi_cnt + 1;
         else if (hi_cnt != 0) begin
            if (sb_q.size() == 0) begin
               n_cmp++; n_bad++;
               $display("FAIL R4: unexpected reset pulse of %0d cycles, expected none", hi_cnt);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               chk("R4 pulse length", 32'(hi_cnt), 32'(e.len));
               chk("R5 standby flag after exit", 32'(stby_flag), 32'(e.stby));
               chk("R6 wake flag after exit", 32'(wake_flag), 32'(e.wake));
            end
            hi_cnt <= 0;
         end
      end
   end

   initial begin : watchdog
      for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      aon_rst_n = 1'b1;
      tick();
      chk("R9 reset pd", 32'(dom_pd), 32'(0));
      chk("R4 reset no rst req", 32'(sys_rst), 32'(0));
      chk("R8 reset I/O driven", 32'(gpio_hiz), 32'(0));
      chk("R5 reset standby flag", 32'(stby_flag), 32'(0));
      chk("R6 reset wake flag", 32'(wake_flag), 32'(0));

      // R2: each missing condition blocks entry
      sleep = 1; deep = 1; pwrdn = 0; tick(); tick();
      chk("R2 no pwrdn select", 32'(gpio_hiz), 32'(0));
      deep = 0; pwrdn = 1; tick(); tick();
      chk("R2 no deep select", 32'(gpio_hiz), 32'(0));
      sleep = 0; deep = 1; tick(); tick();
      chk("R2 no sleep request", 32'(gpio_hiz), 32'(0));

      // R1 entry, R8 pad exceptions
      pin_en = 1; tamper_cfg = 1;
      enter_standby();
      chk("R8 tamper pad kept", 32'(tamper_hiz), 32'(0));
      chk("R8 wakeup pad kept", 32'(wkup_hiz), 32'(0));
      tamper_cfg = 0; #1;
      chk("R8 tamper pad hiz", 32'(tamper_hiz), 32'(1));

      // R3 pin edge exit with latency SYNC+1
      push_exit(1'b1, 1'b1);
      pin = 1;
      tick(); tick();
      chk("R3 still standby before latency", 32'(dom_pd), 32'(1));
      tick();
      chk("R3 reset request after pin edge", 32'(sys_rst), 32'(1));
      chk("R6 wake flag set on pin exit", 32'(wake_flag), 32'(1));
      wait_exit_done();

      // R2: set wake flag blocks entry
      sleep = 1; deep = 1; pwrdn = 1; tick(); tick();
      chk("R2 wake flag blocks entry", 32'(gpio_hiz), 32'(0));
      sleep = 0;
      clr_wake = 1; tick(); clr_wake = 0;
      chk("R6 wake flag cleared", 32'(wake_flag), 32'(0));
      clr_stby = 1; tick(); clr_stby = 0;
      chk("R5 standby flag cleared", 32'(stby_flag), 32'(0));

      // R3: level high at entry does not wake
      enter_standby();
      repeat (8) tick();
      chk("R3 high level at entry ignored", 32'(dom_pd), 32'(1));
      pin_en = 0; pin = 0; tick(); tick();
      pin = 1; repeat (6) tick();
      chk("R3 disabled pin edge ignored", 32'(dom_pd), 32'(1));

      // R3 alarm edge exit
      push_exit(1'b1, 1'b1);
      alarm = 1;
      repeat (SYNC + 1) tick();
      chk("R3 reset request after alarm", 32'(sys_rst), 32'(1));
      wait_exit_done();
      alarm = 0; pin = 0; pin_en = 1;
      clr_wake = 1; tick(); clr_wake = 0;

      // R7 watchdog exit keeps flags, no wake flag (R6)
      enter_standby();
      push_exit(1'b1, 1'b0);
      wdg_rst = 1; tick(); wdg_rst = 0;
      chk("R7 watchdog exit reset request", 32'(sys_rst), 32'(1));
      chk("R6 watchdog leaves wake flag", 32'(wake_flag), 32'(0));
      chk("R7 watchdog keeps standby flag", 32'(stby_flag), 32'(1));
      wait_exit_done();

      // R7 external reset clears flags
      enter_standby();
      push_exit(1'b0, 1'b0);
      ext_rst = 1; tick(); ext_rst = 0;
      chk("R7 ext reset request", 32'(sys_rst), 32'(1));
      chk("R7 ext clears standby flag", 32'(stby_flag), 32'(0));
      chk("R7 ext clears wake flag", 32'(wake_flag), 32'(0));
      chk("R8 I/O hiz during reset", 32'(gpio_hiz), 32'({N_IO{1'b1}}));
      wait_exit_done();

      // R7 watchdog from run
      push_exit(1'b0, 1'b0);
      wdg_rst = 1; tick(); wdg_rst = 0;
      chk("R7 watchdog from run", 32'(sys_rst), 32'(1));
      wait_exit_done();

      tick();
      chk("R4 all pulses seen", 32'(sb_q.size()), 32'(0));
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule